// File: doc/BRIEF.md
# Translation Control Register Legalizer

This block holds the 64-bit control word that tells a page-table walker which paged translation scheme is in force, which identifier tags the current address space, and where the root page table lives. It sits behind a CSR write port. Every accepted write is cleaned up field by field before it is stored, so software always reads back a legal value, and the walker always sees that same value.

One parameter chooses between two personalities. The supervisor personality carries an address-space identifier of up to 16 bits. The guest-stage personality carries a virtual-machine identifier of up to 14 bits and uses the widened (x4) root table, which must be 16 KiB aligned. Further parameters choose which paged modes are built and how many identifier bits exist. Software can learn the identifier width by writing all ones into the field and reading it back.

Top module: `xlat_ctrl_reg`

## Requirements
- R1: After reset the stored word is all zeros, which is bare mode.
- R2: A write with an accepted mode is visible on `csr_rdata` from the cycle after the write strobe. The field layout is mode in bits 63:60, identifier in bits 59:44 and root page number in bits 43:0. A read in the same cycle as the write returns the previous value.
- R3: A write whose mode is one of the reserved codes (1 to 7, or 11 to 15) leaves the whole stored word unchanged.
- R4: A write that selects a paged mode disabled by its enable parameter leaves the whole stored word unchanged. The paged modes are code 8 (39-bit, x4 variant 41-bit), code 9 (48-bit, x4 variant 50-bit) and code 10 (57-bit, x4 variant 59-bit).
- R5: A write of mode code 0 (bare) stores zeros in every other field, whatever the write data holds.
- R6: Identifier bits at or above the implemented length read as zero. Writing all ones into the identifier field reads back as 2^L-1.
- R7: The implemented identifier length is limited to 16 bits in the supervisor personality and to 14 bits in the guest personality, even when the parameter asks for more.
- R8: In the guest personality, with a paged mode, bits 1:0 of the root page number read as zero. In the supervisor personality those bits are stored as written.
- R9: The walker outputs `walk_mode`, `walk_id` and `walk_root_ppn` always equal the matching fields of `csr_rdata`.
- R10: While `csr_we` is low, the stored word does not change, whatever `csr_wdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data in the stored layout |
| csr_rdata | output | 64 | Legalized stored word |
| walk_mode | output | 4 | Current translation mode for the walker |
| walk_id | output | 16 | Current identifier, upper bits zero |
| walk_root_ppn | output | 44 | Root page-table page number |

## Verification
A read and a write can fall in the same cycle. The bench therefore samples `csr_rdata` while the strobe is still high, before the capturing edge, and expects the old word. It samples again after the edge and expects the newly legalized word. Identifier masking and root alignment act together on one write, so random writes drive all-ones identifiers and odd page numbers into two instances: a supervisor one, and a guest one with an over-long identifier length and one mode disabled. A bench model computes every expected word.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int XLEN      = 64;
    localparam int MODE_W    = 4;
    localparam int ID_W      = 16;
    localparam int PPN_W     = 44;
    localparam int ASID_MAX  = 16;
    localparam int VMID_MAX  = 14;

    typedef enum logic [MODE_W-1:0] {
        XM_BARE = 4'd0,
        XM_P39  = 4'd8,
        XM_P48  = 4'd9,
        XM_P57  = 4'd10
    } xlat_mode_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [ID_W-1:0]   id;
        logic [PPN_W-1:0]  ppn;
    } xlat_word_t;

    function automatic int id_len_eff(input bit guest, input int req_len);
        int lim;
        lim = guest ? VMID_MAX : ASID_MAX;
        if (req_len < 0)   return 0;
        if (req_len > lim) return lim;
        return req_len;
    endfunction

    function automatic logic [ID_W-1:0] id_mask(input int len);
        logic [ID_W-1:0] m;
        for (int i = 0; i < ID_W; i++) m[i] = (i < len);
        return m;
    endfunction

endpackage

// File: rtl/xlat_mode_check.sv
module xlat_mode_check
    import xlat_pkg::*;
#(
    parameter bit EN_P39 = 1'b1,
    parameter bit EN_P48 = 1'b1,
    parameter bit EN_P57 = 1'b1
) (
    input  logic [MODE_W-1:0] mode_in,
    output logic              accept
);
    always_comb begin
        unique case (mode_in)
            XM_BARE: accept = 1'b1;
            XM_P39:  accept = EN_P39;
            XM_P48:  accept = EN_P48;
            XM_P57:  accept = EN_P57;
            default: accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/xlat_field_legalize.sv
module xlat_field_legalize
    import xlat_pkg::*;
#(
    parameter bit GUEST  = 1'b0,
    parameter int ID_EFF = 9
) (
    input  xlat_word_t raw,
    output xlat_word_t clean
);
    localparam logic [ID_W-1:0] IDM = id_mask(ID_EFF);

    logic [PPN_W-1:0] ppn_al;

    generate
        if (GUEST) begin : g_wide_root
            assign ppn_al = {raw.ppn[PPN_W-1:2], 2'b00};
        end else begin : g_std_root
            assign ppn_al = raw.ppn;
        end
    endgenerate

    always_comb begin
        if (raw.mode == XM_BARE) begin
            clean = '0;
        end else begin
            clean.mode = raw.mode;
            clean.id   = raw.id & IDM;
            clean.ppn  = ppn_al;
        end
    end
endmodule

// File: rtl/xlat_reg_store.sv
module xlat_reg_store
    import xlat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  xlat_word_t d,
    output xlat_word_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/xlat_ctrl_reg.sv
module xlat_ctrl_reg
    import xlat_pkg::*;
#(
    parameter bit GUEST  = 1'b0,
    parameter int ID_LEN = 9,
    parameter bit EN_P39 = 1'b1,
    parameter bit EN_P48 = 1'b1,
    parameter bit EN_P57 = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    output logic [MODE_W-1:0] walk_mode,
    output logic [ID_W-1:0]  walk_id,
    output logic [PPN_W-1:0] walk_root_ppn
);
    localparam int ID_EFF = id_len_eff(GUEST, ID_LEN);

    xlat_word_t wr_raw, wr_clean, cur;
    logic       mode_ok;

    assign wr_raw = xlat_word_t'(csr_wdata);

    xlat_mode_check #(
        .EN_P39(EN_P39), .EN_P48(EN_P48), .EN_P57(EN_P57)
    ) u_mode (
        .mode_in(wr_raw.mode),
        .accept (mode_ok)
    );

    xlat_field_legalize #(
        .GUEST(GUEST), .ID_EFF(ID_EFF)
    ) u_legal (
        .raw  (wr_raw),
        .clean(wr_clean)
    );

    xlat_reg_store u_store (
        .clk (clk),
        .rst (rst),
        .load(csr_we & mode_ok),
        .d   (wr_clean),
        .q   (cur)
    );

    assign csr_rdata     = cur;
    assign walk_mode     = cur.mode;
    assign walk_id       = cur.id;
    assign walk_root_ppn = cur.ppn;
endmodule

// File: rtl/xlat_ctrl_reg_chk.sv
module xlat_ctrl_reg_chk
    import xlat_pkg::*;
#(
    parameter bit GUEST  = 1'b0,
    parameter int ID_LEN = 9,
    parameter bit EN_P39 = 1'b1,
    parameter bit EN_P48 = 1'b1,
    parameter bit EN_P57 = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              csr_we,
    input logic [XLEN-1:0]   csr_wdata,
    input logic [XLEN-1:0]   csr_rdata,
    input logic [MODE_W-1:0] walk_mode,
    input logic [ID_W-1:0]   walk_id,
    input logic [PPN_W-1:0]  walk_root_ppn
);
    localparam int              ID_EFF = id_len_eff(GUEST, ID_LEN);
    localparam logic [ID_W-1:0] HI_ID  = ~id_mask(ID_EFF);

    logic [3:0] wm, rm;
    logic       w_rsvd, r_legal;
    assign wm = csr_wdata[63:60];
    assign rm = csr_rdata[63:60];
    assign w_rsvd  = (wm != 4'd0) && (wm < 4'd8 || wm > 4'd10);
    assign r_legal = (rm == 4'd0) || (rm == 4'd8 && EN_P39) ||
                     (rm == 4'd9 && EN_P48) || (rm == 4'd10 && EN_P57);

    AST_RESET_BARE: assert property (@(posedge clk)
        $past(rst) |-> csr_rdata == '0);  // R1
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
        csr_we && w_rsvd |=> $stable(csr_rdata));  // R3
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        r_legal);  // R4
    AST_BARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        rm == 4'd0 |-> csr_rdata[59:0] == '0);  // R5
    AST_ID_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata[59:44] & HI_ID) == '0);  // R6
    AST_ROOT_ALIGN: assert property (@(posedge clk) disable iff (rst)
        GUEST && rm != 4'd0 |-> csr_rdata[1:0] == 2'b00);  // R8
    AST_WALK_MATCH: assert property (@(posedge clk) disable iff (rst)
        walk_mode == rm && walk_id == csr_rdata[59:44] &&
        walk_root_ppn == csr_rdata[43:0]);  // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !csr_we |=> $stable(csr_rdata));  // R10
endmodule

bind xlat_ctrl_reg xlat_ctrl_reg_chk #(
    .GUEST(GUEST), .ID_LEN(ID_LEN),
    .EN_P39(EN_P39), .EN_P48(EN_P48), .EN_P57(EN_P57)
) u_chk (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .walk_mode(walk_mode), .walk_id(walk_id),
    .walk_root_ppn(walk_root_ppn)
);

// File: tb/xlat_ctrl_reg_test.sv
module xlat_ctrl_reg_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [63:0] wd  = '0;
    logic [63:0] rd_s, rd_g;
    logic [3:0]  wm_s, wm_g;
    logic [15:0] wi_s, wi_g;
    logic [43:0] wp_s, wp_g;
    logic [63:0] exp_s, exp_g;
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_ctrl_reg uut (
        .clk(clk), .rst(rst), .csr_we(we), .csr_wdata(wd), .csr_rdata(rd_s),
        .walk_mode(wm_s), .walk_id(wi_s), .walk_root_ppn(wp_s));

    xlat_ctrl_reg #(.GUEST(1'b1), .ID_LEN(20), .EN_P57(1'b0)) uut_guest (
        .clk(clk), .rst(rst), .csr_we(we), .csr_wdata(wd), .csr_rdata(rd_g),
        .walk_mode(wm_g), .walk_id(wi_g), .walk_root_ppn(wp_g));

    function automatic logic [63:0] model(logic [63:0] old, logic [63:0] w,
                                          bit guest, int idl, bit e57);
        logic [63:0] r;
        logic [3:0]  m;
        m = w[63:60];
        if (!(m == 4'd0 || m == 4'd8 || m == 4'd9 || (m == 4'd10 && e57)))
            return old;
        if (m == 4'd0) return 64'd0;
        r = w;
        for (int i = 0; i < 16; i++) if (i >= idl) r[44+i] = 1'b0;
        if (guest) r[1:0] = 2'b00;
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_walk(string req);
        check(req, {wm_s, wi_s, wp_s}, rd_s);
        check(req, {wm_g, wi_g, wp_g}, rd_g);
    endtask

    // Write, checking the old value during the strobe cycle and the new one after.
    task automatic do_write(logic [63:0] data, string req);
        @(negedge clk);
        we = 1'b1;
        wd = data;
        #1;
        check("R2 read-during-write", rd_s, exp_s);
        check("R2 read-during-write", rd_g, exp_g);
        exp_s = model(exp_s, data, 1'b0, 9, 1'b1);
        exp_g = model(exp_g, data, 1'b1, 14, 1'b0);
        @(negedge clk);
        we = 1'b0;
        check(req, rd_s, exp_s);
        check(req, rd_g, exp_g);
        check_walk("R9");
    endtask

    function automatic logic [63:0] rnd_word();
        logic [3:0] m;
        logic [63:0] w;
        w = {$urandom, $urandom};
        case ($urandom % 6)
            0: m = 4'd0;
            1: m = 4'd8;
            2: m = 4'd9;
            3: m = 4'd10;
            default: m = 4'($urandom);
        endcase
        if ($urandom % 4 == 0) w[59:44] = 16'hFFFF;
        w[63:60] = m;
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        exp_s = '0;
        exp_g = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset", rd_s, 64'd0);
        check("R1 reset", rd_g, 64'd0);

        // R6 R7: identifier discovery by all-ones write
        do_write({4'd8, 16'hFFFF, 44'h0_0000_1237}, "R2 legal write");
        check("R6 id width", {48'd0, rd_s[59:44]}, 64'h1FF);
        check("R7 id clamp", {48'd0, rd_g[59:44]}, 64'h3FFF);
        check("R8 guest align", {62'd0, rd_g[1:0]}, 64'd0);
        check("R8 supervisor keeps", {62'd0, rd_s[1:0]}, 64'd3);

        // R3: reserved codes change nothing
        do_write({4'd5, 60'hABC_DEF0_1234_567}, "R3 reserved low");
        do_write({4'd13, 60'h111_2222_3333_444}, "R3 reserved high");

        // R4: mode 10 disabled in guest instance only
        do_write({4'd10, 16'h0ABC, 44'hF_FFFF_FFFF}, "R4 disabled mode");
        check("R4 guest unchanged", {60'd0, rd_g[63:60]}, 64'd8);
        check("R4 supervisor took 57", {60'd0, rd_s[63:60]}, 64'd10);

        // R5: bare clears the rest
        do_write({4'd0, 60'hFFF_FFFF_FFFF_FFFF}, "R5 bare zero");

        // R10: data changes without strobe
        do_write({4'd9, 16'h0055, 44'h1_2345_6789}, "R2 legal write");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            wd = {$urandom, $urandom};
        end
        @(negedge clk);
        check("R10 idle hold", rd_s, exp_s);
        check("R10 idle hold", rd_g, exp_g);

        // Random mix
        for (int i = 0; i < 400; i++) do_write(rnd_word(), "R2/R3/R5/R6 random");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule